// File: doc/BRIEF.md
# Three-Channel Programmable Clock Generator

This block produces three independently programmable clock outputs. Each channel picks one of five source clocks and divides it by any whole number from 1 to 256. The source clocks reach the block as single-cycle tick strobes in the block's own clock domain, one strobe per source edge. Each channel output is also a single-cycle strobe: one pulse per divided period. Downstream logic uses it as a clock enable or feeds it to a clock gate. The source clocks themselves are generated outside the block.

Software drives a single write port. Channels are switched on by writing ones to an enable-set address and switched off by writing ones to an enable-clear address. An enable status vector shows which channels are on. Each channel has its own configuration word holding a source code and a divide field. That word is locked while the channel is on, so the sequence is: disable the channel, rewrite its configuration, re-enable it, then wait for its ready flag. Ready flags drive one level interrupt line through a mask that has its own set and clear addresses. When a channel is disabled, it finishes the output period in progress rather than cutting it short.

Top module: `progclk_gen`

## Requirements
- R1: There are three channels. A write to address 0 turns on every channel whose bit in `wr_data_i[2:0]` is 1. A write to address 1 turns off every channel whose bit is 1. Zero bits leave a channel unchanged, and `chan_en_o` shows the enabled channels.
- R2: After reset, every channel is off, every ready flag, output strobe and `irq_o` is low, and each channel is set to the slow clock (code 0) with divide-by-1. Enabling a channel without configuring it gives one pulse per slow tick.
- R3: A write to address 4, 5 or 6 configures channel 0, 1 or 2. The source code is in bits [2:0]: 0 slow, 1 main, 2 master, 3 PLL, 4 USB-PLL divided. The divide field is in bits [15:8].
- R4: Source codes 5, 6 and 7 select the slow clock.
- R5: An enabled channel pulses `chan_tick_o` once every (divide field + 1) ticks of its selected source. A divide field of 0 passes every tick, and 255 gives one pulse per 256 ticks.
- R6: A channel's ready flag goes high on the first tick of its selected source counted after the enable write. It goes low at the same edge that takes the disable write.
- R7: A write to address 2 sets, and a write to address 3 clears, the interrupt mask bits given in `wr_data_i[2:0]`. `irq_o` is high while any ready channel has its mask bit set.
- R8: A channel disabled part-way through a period issues exactly one more pulse, at the normal end of that period, and then stays low. A channel disabled before counting any tick of the current period stops at once.
- R9: A configuration write is ignored while its channel is enabled or still finishing its last period.
- R10: The channels run concurrently with different settings, and none of them affects the rate of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all source ticks are synchronous to it |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick_i | input | 5 | One strobe per source edge: [0] slow, [1] main, [2] master, [3] PLL, [4] USB-PLL divided |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 16 | Write data |
| chan_tick_o | output | 3 | Per-channel divided output strobe |
| chan_en_o | output | 3 | Enable status per channel |
| chan_rdy_o | output | 3 | Ready flag per channel |
| irq_o | output | 1 | Masked OR of the ready flags |

## Verification
The assertions rely on the fact that only one write reaches the block in any cycle, so a channel cannot be enabled and disabled at the same edge. They also assume that write address and data are valid whenever the write strobe is high. The source strobes may arrive in any pattern. The stimulus makes one write per task call, holds the strobe for exactly one cycle, and drives each source with a fixed-period tick (7, 2, 1, 3 and 5 cycles). Measured output intervals are therefore the source period times the divide value. Before every reconfiguration, the stimulus waits longer than the slowest possible period so that the channel has fully stopped.

// File: rtl/progclk_pkg.sv
package progclk_pkg;
  localparam int SEL_W   = 3;
  localparam int DIV_W   = 8;
  localparam int DIV_POS = 8;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_EN_SET = 3'd0,
    A_EN_CLR = 3'd1,
    A_IE_SET = 3'd2,
    A_IE_CLR = 3'd3,
    A_CFG0   = 3'd4
  } addr_e;

  typedef enum logic [SEL_W-1:0] {
    SRC_SLOW   = 3'd0,
    SRC_MAIN   = 3'd1,
    SRC_MASTER = 3'd2,
    SRC_PLL    = 3'd3,
    SRC_USBDIV = 3'd4
  } src_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/progclk_rst_sync.sv
module progclk_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/progclk_src_mux.sv
module progclk_src_mux
  import progclk_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o
);
  // codes beyond the last source fall back to the slow clock (index 0)
  always_comb begin
    tick_o = src_tick_i[0];
    for (int s = 1; s < NUM_SRC; s++) begin
      if (sel_i == SEL_W'(s)) tick_o = src_tick_i[s];
    end
  end
endmodule

// File: rtl/progclk_ctrl.sv
module progclk_ctrl
  import progclk_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NUM_CH-1:0] en_set_o,
  output logic [NUM_CH-1:0] en_clr_o,
  output logic [NUM_CH-1:0] cfg_we_o,
  output chan_cfg_t         cfg_o,
  output logic [NUM_CH-1:0] ien_o
);
  logic [NUM_CH-1:0] mask;
  logic [NUM_CH-1:0] ien_q, ien_d;
  logic              ien_we;
  logic              unused_bits;

  assign mask        = wr_data_i[NUM_CH-1:0];
  assign unused_bits = ^wr_data_i[DIV_POS-1:NUM_CH] ^ ^wr_data_i[NUM_CH-1:SEL_W];
  assign cfg_o.sel   = wr_data_i[SEL_W-1:0];
  assign cfg_o.div   = wr_data_i[DIV_POS +: DIV_W];

  assign en_set_o = (wr_en_i && wr_addr_i == A_EN_SET) ? mask : '0;
  assign en_clr_o = (wr_en_i && wr_addr_i == A_EN_CLR) ? mask : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign cfg_we_o[c] = wr_en_i && (wr_addr_i == ADDR_W'(int'(A_CFG0) + c));
  end

  assign ien_we = wr_en_i && (wr_addr_i == A_IE_SET || wr_addr_i == A_IE_CLR);

  always_comb begin
    ien_d = ien_q;
    if (wr_addr_i == A_IE_SET) ien_d = ien_q | mask;
    else                       ien_d = ien_q & ~mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (ien_we) ien_q <= ien_d;
  end

  assign ien_o = ien_q;
endmodule

// File: rtl/progclk_chan.sv
module progclk_chan
  import progclk_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               cfg_we_i,
  input  chan_cfg_t          cfg_i,
  input  logic               en_set_i,
  input  logic               en_clr_i,
  output logic               en_o,
  output logic               run_o,
  output logic               rdy_o,
  output logic               tick_o,
  output chan_cfg_t          cfg_o
);
  chan_cfg_t        cfg_q;
  logic             en_q, en_d;
  logic             run_q, run_d;
  logic             rdy_q, rdy_d;
  logic             pls_q, pls_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             src_tick;
  logic             cfg_ld;
  logic             period_end;

  progclk_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .src_tick_i (src_tick_i),
    .sel_i      (cfg_q.sel),
    .tick_o     (src_tick)
  );

  assign cfg_ld     = cfg_we_i && !en_q && !run_q;
  assign period_end = run_q && src_tick && (cnt_q == cfg_q.div);

  always_comb begin
    en_d  = en_q;
    run_d = run_q;
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    pls_d = 1'b0;
    if (en_set_i)      en_d = 1'b1;
    else if (en_clr_i) en_d = 1'b0;
    // count ticks; at period end emit one pulse and stop if now disabled
    if (run_q && src_tick) begin
      if (period_end) begin
        pls_d = 1'b1;
        cnt_d = '0;
        run_d = en_d;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
    // nothing counted in this period yet: stop immediately
    if (en_clr_i && !en_set_i && cnt_q == '0) begin
      run_d = 1'b0;
      cnt_d = '0;
    end
    if (en_set_i && !run_q) begin
      run_d = 1'b1;
      cnt_d = '0;
    end
    if (en_clr_i && !en_set_i)              rdy_d = 1'b0;
    else if (en_q && run_q && src_tick)     rdy_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      rdy_q <= 1'b0;
      pls_q <= 1'b0;
      cnt_q <= '0;
      cfg_q <= '{sel: SRC_SLOW, div: '0};
    end else begin
      en_q  <= en_d;
      run_q <= run_d;
      rdy_q <= rdy_d;
      pls_q <= pls_d;
      cnt_q <= cnt_d;
      if (cfg_ld) cfg_q <= cfg_i;
    end
  end

  assign en_o   = en_q;
  assign run_o  = run_q;
  assign rdy_o  = rdy_q;
  assign tick_o = pls_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/progclk_gen.sv
module progclk_gen
  import progclk_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [NUM_CH-1:0]  chan_tick_o,
  output logic [NUM_CH-1:0]  chan_en_o,
  output logic [NUM_CH-1:0]  chan_rdy_o,
  output logic               irq_o
);
  logic                     rst_n_sync;
  logic [NUM_CH-1:0]        en_set, en_clr, cfg_we, ien;
  logic [NUM_CH-1:0]        en_q, run_q, rdy_q;
  chan_cfg_t                wr_cfg;
  chan_cfg_t [NUM_CH-1:0]   cfg_q;

  progclk_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  progclk_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .en_set_o  (en_set),
    .en_clr_o  (en_clr),
    .cfg_we_o  (cfg_we),
    .cfg_o     (wr_cfg),
    .ien_o     (ien)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    progclk_chan #(.NUM_SRC(NUM_SRC)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_n_sync),
      .src_tick_i (src_tick_i),
      .cfg_we_i   (cfg_we[c]),
      .cfg_i      (wr_cfg),
      .en_set_i   (en_set[c]),
      .en_clr_i   (en_clr[c]),
      .en_o       (en_q[c]),
      .run_o      (run_q[c]),
      .rdy_o      (rdy_q[c]),
      .tick_o     (chan_tick_o[c]),
      .cfg_o      (cfg_q[c])
    );
  end

  assign chan_en_o  = en_q;
  assign chan_rdy_o = rdy_q;
  assign irq_o      = |(rdy_q & ien);
endmodule

// File: rtl/progclk_gen_chk.sv
module progclk_gen_chk
  import progclk_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic [ADDR_W-1:0]      wr_addr_i,
  input logic [NUM_CH-1:0]      wr_mask_i,
  input logic [NUM_CH-1:0]      en_i,
  input logic [NUM_CH-1:0]      run_i,
  input logic [NUM_CH-1:0]      rdy_i,
  input logic [NUM_CH-1:0]      tick_i,
  input chan_cfg_t [NUM_CH-1:0] cfg_i,
  input logic                   irq_i
);
  AST_IRQ_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (|rdy_i)); // R7

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_EN_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == A_EN_SET && wr_mask_i[c]) |=> en_i[c]); // R1
    AST_EN_HOLDS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[c] && !(wr_en_i && wr_addr_i == A_EN_SET && wr_mask_i[c])) |=> !en_i[c]); // R1
    AST_CLR_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == A_EN_CLR && wr_mask_i[c]) |=> (!en_i[c] && !rdy_i[c])); // R6
    AST_READY_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdy_i[c] |-> en_i[c]); // R6
    AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i[c] |-> $past(run_i[c])); // R5
    AST_STOPPED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i[c] && !en_i[c]) |=> !tick_i[c]); // R8
    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[c] || run_i[c]) |=> $stable(cfg_i[c])); // R9
  end
endmodule

bind progclk_gen progclk_gen_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_n_sync),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_mask_i (wr_data_i[NUM_CH-1:0]),
  .en_i      (en_q),
  .run_i     (run_q),
  .rdy_i     (rdy_q),
  .tick_i    (chan_tick_o),
  .cfg_i     (cfg_q),
  .irq_i     (irq_o)
);

// File: tb/progclk_gen_tb_top.sv
`timescale 1ns/1ps
module progclk_gen_tb_top;
  localparam int NCH = 3;
  localparam int NSRC = 5;
  localparam int PER [NSRC] = '{7, 2, 1, 3, 5};
  localparam int DVL [4] = '{0, 1, 3, 6};

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_tick;
  logic            wr_en;
  logic [2:0]      wr_addr;
  logic [15:0]     wr_data;
  logic [NCH-1:0]  chan_tick, chan_en, chan_rdy;
  logic            irq;
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  progclk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .chan_tick_o(chan_tick), .chan_en_o(chan_en), .chan_rdy_o(chan_rdy), .irq_o(irq)
  );

  initial begin
    src_tick = '0;
    forever begin
      @(negedge clk);
      for (int s = 0; s < NSRC; s++) src_tick[s] = ((cyc % PER[s]) == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse(input int c, output int at);
    at = -1;
    for (int g = 0; g < 3000; g++) begin
      @(negedge clk);
      if (chan_tick[c]) begin at = cyc; break; end
    end
  endtask

  task automatic measure(input int c, output int iv);
    int t0, t1;
    wait_pulse(c, t0);
    wait_pulse(c, t1);
    iv = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
  endtask

  task automatic count_pulses(input int c, input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (chan_tick[c]) k++;
    end
  endtask

  task automatic cfg_ch(input int c, input int sel, input int div);
    wr(4 + c, (div << 8) | sel);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int iv, k, bad;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    settle(4);
    chk("R2 status in reset", int'(chan_en), 0);
    rst_n = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (chan_tick != 0 || chan_rdy != 0 || irq) bad++;
    end
    chk("R2 outputs quiet after reset", bad, 0);
    chk("R2 status after reset", int'(chan_en), 0);

    // R2 default source and divide: slow clock, divide by 1
    for (int c = 0; c < NCH; c++) begin
      wr(0, 1 << c);
      measure(c, iv);
      chk($sformatf("R2 default rate ch%0d", c), iv, PER[0]);
      wr(1, 1 << c);
    end
    settle(60);

    // R1 set/clear masks
    wr(0, 3'b101);
    chk("R1 set mask 101", int'(chan_en), 5);
    wr(1, 3'b001);
    chk("R1 clear mask 001", int'(chan_en), 4);
    wr(0, 3'b000);
    chk("R1 zero set mask", int'(chan_en), 4);
    wr(1, 3'b100);
    chk("R1 clear last", int'(chan_en), 0);
    settle(60);

    // R3 R5 sweep: every channel, every source, several divides
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < NSRC; s++) begin
        for (int j = 0; j < 4; j++) begin
          wr(1, 1 << c);
          settle(60);
          cfg_ch(c, s, DVL[j]);
          wr(0, 1 << c);
          measure(c, iv);
          chk($sformatf("R3 R5 ch%0d src%0d div%0d", c, s, DVL[j]), iv, PER[s] * (DVL[j] + 1));
          chk($sformatf("R6 ready ch%0d src%0d", c, s), int'(chan_rdy[c]), 1);
        end
      end
    end
    wr(1, 3'b111);
    settle(60);

    // R5 largest divide on the main source
    cfg_ch(0, 1, 255);
    wr(0, 1);
    measure(0, iv);
    chk("R5 divide 256", iv, PER[1] * 256);
    wr(1, 1);
    settle(600);

    // R4 reserved codes fall back to slow
    for (int s = 5; s < 8; s++) begin
      cfg_ch(1, s, 1);
      wr(0, 2);
      measure(1, iv);
      chk($sformatf("R4 code %0d", s), iv, PER[0] * 2);
      wr(1, 2);
      settle(60);
    end

    // R6 exact ready timing with master source (tick every cycle)
    cfg_ch(2, 2, 3);
    wr(0, 4);
    chk("R6 ready low at enable", int'(chan_rdy[2]), 0);
    @(negedge clk);
    chk("R6 ready after first tick", int'(chan_rdy[2]), 1);
    wr(1, 4);
    chk("R6 ready cleared by disable", int'(chan_rdy[2]), 0);
    settle(20);

    // R8 disable mid-period: one more pulse then silence
    cfg_ch(0, 2, 3);
    wr(0, 1);
    wait_pulse(0, k);
    wr(1, 1);
    count_pulses(0, 40, k);
    chk("R8 one closing pulse", k, 1);
    chk("R8 status off", int'(chan_en[0]), 0);

    // R9 configuration locked while enabled
    cfg_ch(1, 2, 1);
    wr(0, 2);
    cfg_ch(1, 2, 5);
    measure(1, iv);
    chk("R9 write ignored while enabled", iv, 2);
    wr(1, 2);
    settle(20);
    wr(0, 2);
    measure(1, iv);
    chk("R9 old setting kept after re-enable", iv, 2);
    wr(1, 2);
    settle(20);

    // R7 interrupt mask
    wr(2, 3'b010);
    wr(0, 2);
    settle(4);
    chk("R7 irq with mask set", int'(irq), 1);
    wr(3, 3'b010);
    chk("R7 irq masked", int'(irq), 0);
    wr(2, 3'b010);
    chk("R7 irq re-armed", int'(irq), 1);
    wr(1, 2);
    chk("R7 irq drops on disable", int'(irq), 0);
    wr(3, 3'b111);
    settle(20);

    // R10 concurrent independent channels
    cfg_ch(0, 0, 1);
    cfg_ch(1, 3, 2);
    cfg_ch(2, 4, 0);
    wr(0, 3'b111);
    chk("R10 all enabled", int'(chan_en), 7);
    measure(0, iv); chk("R10 ch0 rate", iv, 14);
    measure(1, iv); chk("R10 ch1 rate", iv, 9);
    measure(2, iv); chk("R10 ch2 rate", iv, 5);
    wr(1, 3'b101);
    chk("R10 partial disable", int'(chan_en), 2);
    measure(1, iv); chk("R10 ch1 unaffected", iv, 9);
    wr(1, 3'b111);
    settle(60);

    finish_up();
  end
endmodule